// File: doc/BRIEF.md
# Machine-Mode Trap Entry Unit

This block sits beside the fetch stage of a small machine-mode-only processor. It turns single-cycle trap events into a program-counter redirect and an update of the trap registers. The events are five synchronous exceptions, an external interrupt request with an ID, and a return-from-trap. All synchronous exceptions go to one common handler entry. Interrupts are vectored: each one lands four bytes per ID above the handler base. The unit records the interrupted or faulting PC, a cause code and a per-cause trap value. It also keeps the interrupt-enable, previous-enable and previous-privilege status bits.

The handler base is the upper bits of a boot address input. That address is captured into a register on every clock, so it can change after start-up to move the vector table. The unit presents the captured base as a read-only trap-vector value in vectored mode. It also provides the reset fetch address: the boot address with its low byte replaced by 0x80. This address is driven as a redirect for the first cycle after reset.

Redirects, interrupt acknowledges and trap-register updates all appear one clock after the event is sampled. The redirect strobe is high for exactly one cycle.

Top module: `trap_entry_unit`

## Requirements
- R1: A synchronous exception produces, one cycle later, a one-cycle `pc_set_o` pulse with `pc_target_o` = {base[31:8], 8'h00}. The base is the `boot_addr_i` value captured at the previous clock edge.
- R2: An accepted interrupt with ID n (0..31) produces, one cycle later, `pc_set_o` with target {base[31:8], 1'b0, n[4:0], 2'b00}, which equals base plus 4·n. In the same cycle, `irq_ack_o` is high for one cycle and `irq_ack_id_o` = n.
- R3: While reset is held and in the first cycle after release, `pc_set_o` is high and `pc_target_o` = `boot_pc_o` = {boot_addr_i[31:8], 8'h80}. On the next cycle `pc_set_o` is low unless a trap was sampled.
- R4: `trap_vec_base_o` reads {base[31:8], 6'b000000, 2'b01}. The low two bits are the mode field, and 01 means vectored.
- R5: The 6-bit `trap_cause_o` takes bit 5 = 0 for an exception. The low bits hold the code: illegal instruction 2, breakpoint 3, load access fault 5, store access fault 7, environment call 11.
- R6: For an accepted interrupt, `trap_cause_o` = {1'b1, ID[4:0]} and `trap_value_o` = 0.
- R7: On an illegal instruction, `trap_value_o` = `insn_word_i`. When `insn_compressed_i` is set, it is {16'h0000, insn_word_i[15:0]}.
- R8: On a load or store access fault, `trap_value_o` = `lsu_addr_i`. On environment call or breakpoint it is 0.
- R9: Every trap entry does four things: it sets `trap_pc_o` to `cur_pc_i`, copies the interrupt-enable bit into `prev_irq_en_o`, clears `irq_en_o`, and sets `prev_priv_o` to 2'b11.
- R10: When several exception inputs are high together, they are ranked: environment call, illegal instruction, breakpoint, load fault, store fault. Any exception outranks a simultaneous return-from-trap or interrupt.
- R11: An interrupt request is ignored (no redirect, no acknowledge, no register change) while `irq_en_o` is 0, or while an exception or return-from-trap is sampled in the same cycle.
- R12: A return-from-trap redirects to `trap_pc_o`. It sets `irq_en_o` to the previous-enable value and sets `prev_irq_en_o` to 1.
- R13: Reset clears `irq_en_o`, `trap_pc_o`, `trap_cause_o`, `trap_value_o`, `prev_priv_o` and `irq_ack_o`. It sets `prev_irq_en_o` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boot_addr_i | input | 32 | Boot/handler base address, captured every cycle |
| cur_pc_i | input | 32 | PC of the instruction at the trap point |
| insn_word_i | input | 32 | Instruction word at the trap point |
| insn_compressed_i | input | 1 | Instruction at the trap point is 16-bit |
| lsu_addr_i | input | 32 | Address of the last data access |
| ecall_i | input | 1 | Environment call event |
| illegal_i | input | 1 | Illegal instruction event |
| ebreak_i | input | 1 | Breakpoint event |
| load_fault_i | input | 1 | Load access fault event |
| store_fault_i | input | 1 | Store access fault event |
| mret_i | input | 1 | Return-from-trap event |
| irq_req_i | input | 1 | Interrupt request |
| irq_id_i | input | 5 | ID of the requesting interrupt |
| pc_set_o | output | 1 | One-cycle redirect strobe |
| pc_target_o | output | 32 | Redirect address |
| irq_ack_o | output | 1 | Interrupt accepted |
| irq_ack_id_o | output | 5 | ID of the accepted interrupt |
| trap_pc_o | output | 32 | Saved trap PC |
| trap_cause_o | output | 6 | Saved cause code |
| trap_value_o | output | 32 | Saved trap value |
| irq_en_o | output | 1 | Global interrupt enable |
| prev_irq_en_o | output | 1 | Enable value before the last trap |
| prev_priv_o | output | 2 | Privilege before the last trap |
| trap_vec_base_o | output | 32 | Read-only trap-vector base with mode field |
| boot_pc_o | output | 32 | Reset fetch address |

## Verification
The hardest state to reach is an interrupt being taken. The enable bit comes out of reset cleared, and no port writes it directly. The only way to set it is a return-from-trap, which copies the previous-enable bit, and every trap entry clears it again. The stimulus therefore puts a return-from-trap in front of every interrupt in the 32-ID sweep, which it repeats for several bases. It also issues interrupts on purpose right after a trap entry, and alongside exceptions, so that the ignored cases are observed at the ports.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    // What the arbiter decided to do with the current cycle's events
    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_EXC,
        KIND_IRQ,
        KIND_RET
    } trap_kind_e;

    // Which source feeds the trap value register
    typedef enum logic [1:0] {
        TVAL_ZERO,
        TVAL_INSN,
        TVAL_HALF,
        TVAL_ADDR
    } tval_src_e;

    // Exception codes (the low bits of the cause field)
    localparam logic [4:0] CODE_ILLEGAL = 5'd2;
    localparam logic [4:0] CODE_BREAK   = 5'd3;
    localparam logic [4:0] CODE_LOAD    = 5'd5;
    localparam logic [4:0] CODE_STORE   = 5'd7;
    localparam logic [4:0] CODE_ECALL   = 5'd11;

    localparam logic [1:0] PRIV_MACHINE = 2'b11;

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_entry_pkg::*;
#(
    parameter int IRQ_ID_W = 5,
    parameter int CAUSE_W  = 6
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                ecall_i,
    input  logic                illegal_i,
    input  logic                ebreak_i,
    input  logic                load_fault_i,
    input  logic                store_fault_i,
    input  logic                mret_i,
    input  logic                irq_req_i,
    input  logic [IRQ_ID_W-1:0] irq_id_i,
    input  logic                irq_en_i,
    input  logic                compressed_i,
    output trap_kind_e          kind_o,
    output logic [CAUSE_W-1:0]  cause_o,
    output tval_src_e           tval_src_o
);

    localparam int CODE_W = CAUSE_W - 1;

    logic any_exc;
    assign any_exc = ecall_i | illegal_i | ebreak_i | load_fault_i | store_fault_i;

    // Fixed priority: ecall, illegal, ebreak, load, store, return, interrupt
    always_comb begin
        kind_o     = KIND_NONE;
        cause_o    = '0;
        tval_src_o = TVAL_ZERO;
        if (ecall_i) begin
            kind_o  = KIND_EXC;
            cause_o = {1'b0, CODE_W'(CODE_ECALL)};
        end else if (illegal_i) begin
            kind_o     = KIND_EXC;
            cause_o    = {1'b0, CODE_W'(CODE_ILLEGAL)};
            tval_src_o = compressed_i ? TVAL_HALF : TVAL_INSN;
        end else if (ebreak_i) begin
            kind_o  = KIND_EXC;
            cause_o = {1'b0, CODE_W'(CODE_BREAK)};
        end else if (load_fault_i) begin
            kind_o     = KIND_EXC;
            cause_o    = {1'b0, CODE_W'(CODE_LOAD)};
            tval_src_o = TVAL_ADDR;
        end else if (store_fault_i) begin
            kind_o     = KIND_EXC;
            cause_o    = {1'b0, CODE_W'(CODE_STORE)};
            tval_src_o = TVAL_ADDR;
        end else if (mret_i) begin
            kind_o = KIND_RET;
        end else if (irq_req_i && irq_en_i) begin
            kind_o  = KIND_IRQ;
            cause_o = {1'b1, CODE_W'(irq_id_i)};
        end
    end

    // R10: any exception input wins over return and interrupt
    assert_exc_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_exc |-> (kind_o == KIND_EXC));

    // R5: exception causes never carry the interrupt flag
    assert_exc_cause_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kind_o == KIND_EXC) |-> !cause_o[CAUSE_W-1]);

endmodule

// File: rtl/trap_vector.sv
module trap_vector
    import trap_entry_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int IRQ_ID_W = 5,
    parameter int ALIGN_W  = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [ADDR_W-1:0]   boot_addr_i,
    input  logic [ADDR_W-1:0]   trap_pc_i,
    input  trap_kind_e          kind_i,
    input  logic [IRQ_ID_W-1:0] irq_id_i,
    output logic [ADDR_W-1:0]   target_o,
    output logic [ADDR_W-1:0]   vec_base_o,
    output logic [ADDR_W-1:0]   boot_pc_o
);

    localparam int HI_W = ADDR_W - ALIGN_W;
    localparam logic [ALIGN_W-1:0] RESET_OFF     = ALIGN_W'(1) << (ALIGN_W - 1);
    localparam logic [ALIGN_W-1:0] MODE_VECTORED = ALIGN_W'(1);

    logic [HI_W-1:0]    base_hi;
    logic [ALIGN_W-1:0] irq_off;

    assign base_hi = base_i[ADDR_W-1:ALIGN_W];
    assign irq_off = ALIGN_W'({irq_id_i, 2'b00});

    always_comb begin
        unique case (kind_i)
            KIND_EXC: target_o = {base_hi, {ALIGN_W{1'b0}}};
            KIND_IRQ: target_o = {base_hi, irq_off};
            KIND_RET: target_o = trap_pc_i;
            default:  target_o = '0;
        endcase
    end

    assign vec_base_o = {base_hi, MODE_VECTORED};
    assign boot_pc_o  = {boot_addr_i[ADDR_W-1:ALIGN_W], RESET_OFF};

    // R2: interrupt entries stay inside the aligned table, word aligned
    assert_irq_in_table_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kind_i == KIND_IRQ) |->
            (target_o[ADDR_W-1:ALIGN_W] == vec_base_o[ADDR_W-1:ALIGN_W]) && (target_o[1:0] == 2'b00));

    // R1: the common exception entry sits on the table's first word
    assert_exc_entry_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kind_i == KIND_EXC) |-> (target_o == (vec_base_o & ~ADDR_W'(MODE_VECTORED))));

endmodule

// File: rtl/trap_state.sv
module trap_state
    import trap_entry_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int IRQ_ID_W = 5,
    parameter int CAUSE_W  = 6
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [ADDR_W-1:0]   boot_addr_i,
    input  logic [ADDR_W-1:0]   cur_pc_i,
    input  logic [ADDR_W-1:0]   insn_word_i,
    input  logic [ADDR_W-1:0]   lsu_addr_i,
    input  logic [IRQ_ID_W-1:0] irq_id_i,
    input  trap_kind_e          kind_i,
    input  logic [CAUSE_W-1:0]  cause_i,
    input  tval_src_e           tval_src_i,
    input  logic [ADDR_W-1:0]   target_i,
    output logic [ADDR_W-1:0]   base_o,
    output logic [ADDR_W-1:0]   trap_pc_o,
    output logic [CAUSE_W-1:0]  cause_o,
    output logic [ADDR_W-1:0]   tval_o,
    output logic                irq_en_o,
    output logic                prev_irq_en_o,
    output logic [1:0]          prev_priv_o,
    output logic                pc_set_o,
    output logic [ADDR_W-1:0]   target_o,
    output logic                ack_o,
    output logic [IRQ_ID_W-1:0] ack_id_o,
    output logic                boot_pend_o
);

    typedef struct packed {
        logic [ADDR_W-1:0]   base;
        logic [ADDR_W-1:0]   trap_pc;
        logic [CAUSE_W-1:0]  cause;
        logic [ADDR_W-1:0]   tval;
        logic                irq_en;
        logic                prev_irq_en;
        logic [1:0]          prev_priv;
        logic                pc_set;
        logic [ADDR_W-1:0]   target;
        logic                ack;
        logic [IRQ_ID_W-1:0] ack_id;
        logic                boot_pend;
    } state_t;

    state_t st_d, st_q;
    logic [ADDR_W-1:0] tval_sel;

    always_comb begin
        unique case (tval_src_i)
            TVAL_INSN: tval_sel = insn_word_i;
            TVAL_HALF: tval_sel = ADDR_W'(insn_word_i[15:0]);
            TVAL_ADDR: tval_sel = lsu_addr_i;
            default:   tval_sel = '0;
        endcase
    end

    always_comb begin
        st_d           = st_q;
        st_d.base      = boot_addr_i;
        st_d.boot_pend = 1'b0;
        st_d.pc_set    = (kind_i != KIND_NONE);
        st_d.ack       = (kind_i == KIND_IRQ);
        if (kind_i != KIND_NONE) begin
            st_d.target = target_i;
        end
        unique case (kind_i)
            KIND_EXC, KIND_IRQ: begin
                st_d.trap_pc     = cur_pc_i;
                st_d.cause       = cause_i;
                st_d.tval        = (kind_i == KIND_EXC) ? tval_sel : '0;
                st_d.prev_irq_en = st_q.irq_en;
                st_d.irq_en      = 1'b0;
                st_d.prev_priv   = PRIV_MACHINE;
                if (kind_i == KIND_IRQ) begin
                    st_d.ack_id = irq_id_i;
                end
            end
            KIND_RET: begin
                st_d.irq_en      = st_q.prev_irq_en;
                st_d.prev_irq_en = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{base: '0, trap_pc: '0, cause: '0, tval: '0, irq_en: 1'b0,
                      prev_irq_en: 1'b1, prev_priv: 2'b00, pc_set: 1'b0, target: '0,
                      ack: 1'b0, ack_id: '0, boot_pend: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign base_o        = st_q.base;
    assign trap_pc_o     = st_q.trap_pc;
    assign cause_o       = st_q.cause;
    assign tval_o        = st_q.tval;
    assign irq_en_o      = st_q.irq_en;
    assign prev_irq_en_o = st_q.prev_irq_en;
    assign prev_priv_o   = st_q.prev_priv;
    assign pc_set_o      = st_q.pc_set;
    assign target_o      = st_q.target;
    assign ack_o         = st_q.ack;
    assign ack_id_o      = st_q.ack_id;
    assign boot_pend_o   = st_q.boot_pend;

    // R9: a trap entry leaves interrupts masked in machine mode
    assert_entry_masks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((kind_i == KIND_EXC) || (kind_i == KIND_IRQ)) |=>
            (!st_q.irq_en && (st_q.prev_priv == PRIV_MACHINE)));

    // R12: return restores the enable from its saved copy
    assert_ret_restore_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kind_i == KIND_RET) |=> (st_q.irq_en == $past(st_q.prev_irq_en)) && st_q.prev_irq_en);

    // R11: an interrupt is only accepted while enabled
    assert_irq_gated_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kind_i == KIND_IRQ) |-> st_q.irq_en);

    // R2: acknowledge never lasts two cycles
    assert_ack_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.ack |=> !st_q.ack);

    // R3: the boot redirect appears only once
    assert_boot_once_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.boot_pend |=> !st_q.boot_pend);

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_entry_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int IRQ_ID_W = 5,
    parameter int CAUSE_W  = 6,
    parameter int ALIGN_W  = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [ADDR_W-1:0]   boot_addr_i,
    input  logic [ADDR_W-1:0]   cur_pc_i,
    input  logic [ADDR_W-1:0]   insn_word_i,
    input  logic                insn_compressed_i,
    input  logic [ADDR_W-1:0]   lsu_addr_i,
    input  logic                ecall_i,
    input  logic                illegal_i,
    input  logic                ebreak_i,
    input  logic                load_fault_i,
    input  logic                store_fault_i,
    input  logic                mret_i,
    input  logic                irq_req_i,
    input  logic [IRQ_ID_W-1:0] irq_id_i,
    output logic                pc_set_o,
    output logic [ADDR_W-1:0]   pc_target_o,
    output logic                irq_ack_o,
    output logic [IRQ_ID_W-1:0] irq_ack_id_o,
    output logic [ADDR_W-1:0]   trap_pc_o,
    output logic [CAUSE_W-1:0]  trap_cause_o,
    output logic [ADDR_W-1:0]   trap_value_o,
    output logic                irq_en_o,
    output logic                prev_irq_en_o,
    output logic [1:0]          prev_priv_o,
    output logic [ADDR_W-1:0]   trap_vec_base_o,
    output logic [ADDR_W-1:0]   boot_pc_o
);

    trap_kind_e        kind;
    tval_src_e         tval_src;
    logic [CAUSE_W-1:0] cause;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] next_target;
    logic [ADDR_W-1:0] target_q;
    logic              pc_set_q;
    logic              boot_pend;

    trap_arbiter #(
        .IRQ_ID_W (IRQ_ID_W),
        .CAUSE_W  (CAUSE_W)
    ) u_arbiter (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .ecall_i       (ecall_i),
        .illegal_i     (illegal_i),
        .ebreak_i      (ebreak_i),
        .load_fault_i  (load_fault_i),
        .store_fault_i (store_fault_i),
        .mret_i        (mret_i),
        .irq_req_i     (irq_req_i),
        .irq_id_i      (irq_id_i),
        .irq_en_i      (irq_en_o),
        .compressed_i  (insn_compressed_i),
        .kind_o        (kind),
        .cause_o       (cause),
        .tval_src_o    (tval_src)
    );

    trap_vector #(
        .ADDR_W   (ADDR_W),
        .IRQ_ID_W (IRQ_ID_W),
        .ALIGN_W  (ALIGN_W)
    ) u_vector (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .base_i      (base_q),
        .boot_addr_i (boot_addr_i),
        .trap_pc_i   (trap_pc_o),
        .kind_i      (kind),
        .irq_id_i    (irq_id_i),
        .target_o    (next_target),
        .vec_base_o  (trap_vec_base_o),
        .boot_pc_o   (boot_pc_o)
    );

    trap_state #(
        .ADDR_W   (ADDR_W),
        .IRQ_ID_W (IRQ_ID_W),
        .CAUSE_W  (CAUSE_W)
    ) u_state (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .boot_addr_i   (boot_addr_i),
        .cur_pc_i      (cur_pc_i),
        .insn_word_i   (insn_word_i),
        .lsu_addr_i    (lsu_addr_i),
        .irq_id_i      (irq_id_i),
        .kind_i        (kind),
        .cause_i       (cause),
        .tval_src_i    (tval_src),
        .target_i      (next_target),
        .base_o        (base_q),
        .trap_pc_o     (trap_pc_o),
        .cause_o       (trap_cause_o),
        .tval_o        (trap_value_o),
        .irq_en_o      (irq_en_o),
        .prev_irq_en_o (prev_irq_en_o),
        .prev_priv_o   (prev_priv_o),
        .pc_set_o      (pc_set_q),
        .target_o      (target_q),
        .ack_o         (irq_ack_o),
        .ack_id_o      (irq_ack_id_o),
        .boot_pend_o   (boot_pend)
    );

    assign pc_set_o    = boot_pend | pc_set_q;
    assign pc_target_o = boot_pend ? boot_pc_o : target_q;

    // R2: every acknowledge comes with a redirect
    assert_ack_redirects_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_ack_o |-> pc_set_o);

endmodule

// File: tb/trap_entry_unit_tb_top.sv
module trap_entry_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] boot_addr = '0;
    logic [31:0] cur_pc = '0;
    logic [31:0] insn_word = '0;
    logic        insn_comp = 1'b0;
    logic [31:0] lsu_addr = '0;
    logic        ecall = 1'b0, illegal = 1'b0, ebreak = 1'b0, ld_f = 1'b0, st_f = 1'b0;
    logic        mret = 1'b0, irq_req = 1'b0;
    logic [4:0]  irq_id = '0;

    logic        pc_set, irq_ack, irq_en, prev_irq_en;
    logic [31:0] pc_target, trap_pc, trap_value, vec_base, boot_pc;
    logic [4:0]  irq_ack_id;
    logic [5:0]  trap_cause;
    logic [1:0]  prev_priv;

    always #(CLK_PERIOD / 2) clk = ~clk;

    trap_entry_unit dut_i (
        .clk_i             (clk),
        .rst_ni            (rst_n),
        .boot_addr_i       (boot_addr),
        .cur_pc_i          (cur_pc),
        .insn_word_i       (insn_word),
        .insn_compressed_i (insn_comp),
        .lsu_addr_i        (lsu_addr),
        .ecall_i           (ecall),
        .illegal_i         (illegal),
        .ebreak_i          (ebreak),
        .load_fault_i      (ld_f),
        .store_fault_i     (st_f),
        .mret_i            (mret),
        .irq_req_i         (irq_req),
        .irq_id_i          (irq_id),
        .pc_set_o          (pc_set),
        .pc_target_o       (pc_target),
        .irq_ack_o         (irq_ack),
        .irq_ack_id_o      (irq_ack_id),
        .trap_pc_o         (trap_pc),
        .trap_cause_o      (trap_cause),
        .trap_value_o      (trap_value),
        .irq_en_o          (irq_en),
        .prev_irq_en_o     (prev_irq_en),
        .prev_priv_o       (prev_priv),
        .trap_vec_base_o   (vec_base),
        .boot_pc_o         (boot_pc)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // Bench model of the architectural state
    logic [31:0] m_base, m_mepc, m_tval;
    logic [5:0]  m_cause;
    logic        m_mie, m_mpie;
    logic [1:0]  m_mpp;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // exc bits: [0] ecall, [1] illegal, [2] ebreak, [3] load fault, [4] store fault
    task automatic step(input logic [4:0] exc, input logic ret, input logic irq,
                        input logic [4:0] id, input logic comp,
                        input logic [31:0] pc, input logic [31:0] insn, input logic [31:0] addr);
        logic        t_exc, t_ret, t_irq, any;
        logic [31:0] exp_tgt, tv;
        logic [4:0]  code;
        string       ctag, vtag, ttag;
        @(negedge clk);
        ecall = exc[0]; illegal = exc[1]; ebreak = exc[2]; ld_f = exc[3]; st_f = exc[4];
        mret = ret; irq_req = irq; irq_id = id; insn_comp = comp;
        cur_pc = pc; insn_word = insn; lsu_addr = addr;
        @(negedge clk);
        ecall = 0; illegal = 0; ebreak = 0; ld_f = 0; st_f = 0; mret = 0; irq_req = 0;
        t_exc = |exc;
        t_ret = !t_exc && ret;
        t_irq = !t_exc && !ret && irq && m_mie;
        any = t_exc | t_ret | t_irq;
        exp_tgt = '0; code = '0; tv = '0;
        ctag = ($countones(exc) > 1) ? "R10" : "R5";
        vtag = "R8";
        ttag = t_irq ? "R2" : (t_ret ? "R12" : "R1");
        if (t_exc) begin
            if (exc[0])      begin code = 5'd11; tv = '0; end
            else if (exc[1]) begin code = 5'd2; tv = comp ? {16'h0, insn[15:0]} : insn; vtag = "R7"; end
            else if (exc[2]) begin code = 5'd3; tv = '0; end
            else if (exc[3]) begin code = 5'd5; tv = addr; end
            else             begin code = 5'd7; tv = addr; end
            exp_tgt = {m_base[31:8], 8'h00};
            m_mepc = pc; m_cause = {1'b0, code}; m_tval = tv;
            m_mpie = m_mie; m_mie = 1'b0; m_mpp = 2'b11;
        end else if (t_ret) begin
            exp_tgt = m_mepc;
            m_mie = m_mpie; m_mpie = 1'b1;
        end else if (t_irq) begin
            exp_tgt = {m_base[31:8], 1'b0, id, 2'b00};
            m_mepc = pc; m_cause = {1'b1, id}; m_tval = '0;
            m_mpie = m_mie; m_mie = 1'b0; m_mpp = 2'b11;
            ctag = "R6"; vtag = "R6";
        end
        if (irq && !t_irq) ttag = t_exc ? "R10" : "R11";
        chk(ttag, 32'(pc_set), 32'(any));
        if (any) chk(ttag, pc_target, exp_tgt);
        chk(irq && !t_irq ? "R11" : "R2", 32'(irq_ack), 32'(t_irq));
        if (t_irq) chk("R2", 32'(irq_ack_id), 32'(id));
        chk(irq && !t_irq ? "R11" : ctag, 32'(trap_cause), 32'(m_cause));
        chk(irq && !t_irq ? "R11" : vtag, trap_value, m_tval);
        chk("R9", trap_pc, m_mepc);
        chk(t_ret ? "R12" : "R9", 32'(irq_en), 32'(m_mie));
        chk(t_ret ? "R12" : "R9", 32'(prev_irq_en), 32'(m_mpie));
        chk("R9", 32'(prev_priv), 32'(m_mpp));
        chk("R4", vec_base, {m_base[31:8], 8'h01});
        @(negedge clk);
        chk("R1", 32'(pc_set), 32'(0));
        chk("R2", 32'(irq_ack), 32'(0));
    endtask

    task automatic set_boot(input logic [31:0] v);
        @(negedge clk);
        boot_addr = v;
        @(negedge clk);
        m_base = v;
        chk("R4", vec_base, {v[31:8], 8'h01});
        chk("R3", boot_pc, {v[31:8], 8'h80});
    endtask

    initial begin
        m_base = '0; m_mepc = '0; m_tval = '0; m_cause = '0;
        m_mie = 1'b0; m_mpie = 1'b1; m_mpp = 2'b00;
        boot_addr = 32'h8000_1A55;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3", 32'(pc_set), 32'(1));
        rst_n = 1'b1;
        chk("R3", 32'(pc_set), 32'(1));
        chk("R3", pc_target, 32'h8000_1A80);
        chk("R3", boot_pc, 32'h8000_1A80);
        chk("R13", 32'(irq_en), 32'(0));
        chk("R13", 32'(prev_irq_en), 32'(1));
        chk("R13", 32'(prev_priv), 32'(0));
        chk("R13", trap_pc, 32'h0);
        chk("R13", 32'(trap_cause), 32'h0);
        chk("R13", trap_value, 32'h0);
        chk("R13", 32'(irq_ack), 32'(0));
        @(negedge clk);
        m_base = boot_addr;
        chk("R3", 32'(pc_set), 32'(0));
        chk("R4", vec_base, 32'h8000_1A01);

        // Interrupt while disabled out of reset
        step(5'b00000, 1'b0, 1'b1, 5'd9, 1'b0, 32'h100, 32'h0, 32'h0);
        // Return enables interrupts from the previous-enable copy
        step(5'b00000, 1'b1, 1'b0, 5'd0, 1'b0, 32'h104, 32'h0, 32'h0);

        // Each exception alone, followed by a return
        for (int e = 0; e < 5; e++) begin
            step(5'(1 << e), 1'b0, 1'b0, 5'd0, 1'b0, 32'h2000 + 32'(e * 4),
                 32'hC0DE_0000 | 32'(e), 32'hA000_0000 + 32'(e * 16));
            step(5'b00000, 1'b1, 1'b0, 5'd0, 1'b0, 32'h0, 32'h0, 32'h0);
        end
        // Compressed illegal instruction
        step(5'b00010, 1'b0, 1'b0, 5'd0, 1'b1, 32'h3002, 32'hFFFF_8A41, 32'h0);
        step(5'b00000, 1'b1, 1'b0, 5'd0, 1'b0, 32'h0, 32'h0, 32'h0);

        // Interrupt ID sweep over several bases
        for (int b = 0; b < 3; b++) begin
            set_boot(32'h0000_1000 * 32'(b + 1) + 32'h0004_0000 * 32'(b) + 32'h7F);
            for (int i = 0; i < 32; i++) begin
                step(5'b00000, 1'b1, 1'b0, 5'd0, 1'b0, 32'h0, 32'h0, 32'h0);
                step(5'b00000, 1'b0, 1'b1, 5'(i), 1'b0, 32'h4000 + 32'(i * 4), 32'h0, 32'h0);
            end
            // Interrupt right after entry: enable is now clear
            step(5'b00000, 1'b0, 1'b1, 5'd3, 1'b0, 32'h5000, 32'h0, 32'h0);
        end

        // Interrupt alongside an exception, and alongside a return
        step(5'b00000, 1'b1, 1'b0, 5'd0, 1'b0, 32'h0, 32'h0, 32'h0);
        step(5'b01000, 1'b0, 1'b1, 5'd17, 1'b0, 32'h6000, 32'h0, 32'h6666_0000);
        step(5'b00000, 1'b1, 1'b1, 5'd17, 1'b0, 32'h6004, 32'h0, 32'h0);

        // Priority sweep over every combination of exception inputs
        for (int m = 1; m < 32; m++) begin
            step(5'(m), 1'(m[0] ^ m[4]), 1'(m[1]), 5'(m), 1'(m[2]),
                 32'h7000 + 32'(m * 4), 32'h1357_0000 | 32'(m), 32'hB000_0000 | 32'(m));
            step(5'b00000, 1'b1, 1'b0, 5'd0, 1'b0, 32'h0, 32'h0, 32'h0);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R13 watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule